// File: doc/BRIEF.md
# High-Speed Mode Entry and Conversion Clock Stretch

This block sits beside the byte engine of a two-wire bus slave that fronts a sampling converter. It watches the bus events and received bytes the front end has already synchronized. When the first byte after a START, seen while the bus runs at standard or fast speed, carries the high-speed preamble pattern, the block asks the front end to leave that byte unacknowledged. It then switches to high-speed operation at the next START. High-speed operation survives any number of repeated STARTs and ends only at a STOP.

In high-speed operation a conversion cannot finish between a repeated START and the end of the read-address byte. So once the block accepts a read address for this device, it drives an open-drain hold enable that keeps the clock line low. The hold drops on the clock after the converter signals completion. A parameterized cycle limit also drops it if completion never comes. At standard or fast speed the block never stretches.

Top module: `hs_stretch_ctrl`

## Requirements
- R1: After reset, hs_mode, scl_hold and mc_nack are all low.
- R2: A byte whose top five bits are 00001, received as the first byte after a START while hs_mode is low, raises mc_nack for exactly the one cycle after its byte_valid cycle. hs_mode stays low at that point.
- R3: After such a preamble byte, hs_mode rises in the cycle after the next start_evt.
- R4: A byte with the preamble pattern that is not the first byte after a START, or that arrives while hs_mode is high, produces no mc_nack. It also does not make a later START raise hs_mode.
- R5: A start_evt while hs_mode is high leaves hs_mode high.
- R6: A stop_evt clears hs_mode, any pending preamble and scl_hold from the next cycle on.
- R7: While hs_mode is high, a first byte after a START equal to {5'b10010, addr_sel, 1'b1} (bits 7:3 prefix, bits 2:1 select, bit 0 read) raises scl_hold from the next cycle. A write bit, a different select or a later byte does not.
- R8: scl_hold is never high while hs_mode is low. A matching read address at standard or fast speed causes no stretch.
- R9: scl_hold falls in the cycle after a cycle in which conv_done is high.
- R10: Without conv_done, scl_hold stays high for exactly STRETCH_LIMIT cycles and then falls.
- R11: If conv_done is high in the same cycle the read address is accepted, scl_hold does not rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_sel | input | 2 | Device select bits strapped on the board |
| start_evt | input | 1 | One-cycle pulse on START or repeated START |
| stop_evt | input | 1 | One-cycle pulse on STOP |
| byte_valid | input | 1 | One-cycle pulse when a full byte has been received |
| byte_data | input | 8 | Received byte, valid with byte_valid |
| conv_done | input | 1 | Converter completion pulse |
| hs_mode | output | 1 | High-speed operation active |
| scl_hold | output | 1 | Open-drain enable that pulls the clock line low |
| mc_nack | output | 1 | Request to leave the current byte unacknowledged |

## Verification
Two release paths can fall in the same cycle: the completion pulse that ends a stretch can coincide with the acceptance of the read address that would start one. The bench drives byte_valid with a matching high-speed read address and conv_done together on one edge. It judges the case correct only if scl_hold stays low in the next cycle and later ones. It also drives a STOP during an active stretch and expects the stretch and high-speed state to clear together.

// File: rtl/hs_stretch_pkg.sv
package hs_stretch_pkg;
    localparam logic [4:0] PREAMBLE_TOP = 5'b00001;
    localparam logic [4:0] DEV_PREFIX   = 5'b10010;

    typedef struct packed {
        logic first;
        logic armed;
        logic hs;
        logic nack;
    } mode_state_t;
endpackage

// File: rtl/hs_byte_decode.sv
module hs_byte_decode
    import hs_stretch_pkg::*;
(
    input  logic [7:0] byte_data,
    input  logic [1:0] addr_sel,
    output logic       is_preamble,
    output logic       is_own_read
);
    always_comb begin
        is_preamble = (byte_data[7:3] == PREAMBLE_TOP);
        is_own_read = (byte_data[7:3] == DEV_PREFIX) &&
                      (byte_data[2:1] == addr_sel) &&
                      byte_data[0];
    end
endmodule

// File: rtl/hs_mode_fsm.sv
module hs_mode_fsm
    import hs_stretch_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_evt,
    input  logic stop_evt,
    input  logic byte_valid,
    input  logic is_preamble,
    output logic hs_mode,
    output logic first_byte,
    output logic mc_nack
);
    mode_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.nack = 1'b0;
        if (start_evt) begin
            st_d.first = 1'b1;
            if (st_q.armed) begin
                st_d.hs    = 1'b1;
                st_d.armed = 1'b0;
            end
        end
        if (byte_valid && st_q.first) begin
            st_d.first = 1'b0;
            if (!st_q.hs && is_preamble) begin
                st_d.armed = 1'b1;
                st_d.nack  = 1'b1;
            end
        end
        if (stop_evt) begin
            st_d.first = 1'b0;
            st_d.armed = 1'b0;
            st_d.hs    = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign hs_mode    = st_q.hs;
    assign first_byte = st_q.first;
    assign mc_nack    = st_q.nack;
endmodule

// File: rtl/hs_stretch_timer.sv
module hs_stretch_timer #(
    parameter int STRETCH_LIMIT = 300
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stop_evt,
    input  logic arm,
    input  logic conv_done,
    output logic scl_hold
);
    localparam int CW = $clog2(STRETCH_LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(STRETCH_LIMIT - 1);

    typedef struct packed {
        logic          hold;
        logic [CW-1:0] cnt;
    } timer_state_t;

    timer_state_t tm_d, tm_q;

    always_comb begin
        tm_d = tm_q;
        if (tm_q.hold) begin
            if (conv_done || tm_q.cnt == LAST) begin
                tm_d.hold = 1'b0;
                tm_d.cnt  = '0;
            end else begin
                tm_d.cnt = tm_q.cnt + 1'b1;
            end
        end else if (arm && !conv_done) begin
            tm_d.hold = 1'b1;
            tm_d.cnt  = '0;
        end
        if (stop_evt) begin
            tm_d.hold = 1'b0;
            tm_d.cnt  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tm_q <= '0;
        else        tm_q <= tm_d;
    end

    assign scl_hold = tm_q.hold;
endmodule

// File: rtl/hs_stretch_ctrl.sv
module hs_stretch_ctrl #(
    parameter int STRETCH_LIMIT = 300
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] addr_sel,
    input  logic       start_evt,
    input  logic       stop_evt,
    input  logic       byte_valid,
    input  logic [7:0] byte_data,
    input  logic       conv_done,
    output logic       hs_mode,
    output logic       scl_hold,
    output logic       mc_nack
);
    logic is_preamble, is_own_read, first_byte, arm_hold;

    hs_byte_decode u_dec (
        .byte_data   (byte_data),
        .addr_sel    (addr_sel),
        .is_preamble (is_preamble),
        .is_own_read (is_own_read)
    );

    hs_mode_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_evt   (start_evt),
        .stop_evt    (stop_evt),
        .byte_valid  (byte_valid),
        .is_preamble (is_preamble),
        .hs_mode     (hs_mode),
        .first_byte  (first_byte),
        .mc_nack     (mc_nack)
    );

    // stretch only for the read address that opens a high-speed transfer
    assign arm_hold = byte_valid && first_byte && hs_mode && is_own_read;

    hs_stretch_timer #(.STRETCH_LIMIT(STRETCH_LIMIT)) u_tmr (
        .clk       (clk),
        .rst_n     (rst_n),
        .stop_evt  (stop_evt),
        .arm       (arm_hold),
        .conv_done (conv_done),
        .scl_hold  (scl_hold)
    );
endmodule

// File: rtl/hs_stretch_ctrl_chk.sv
module hs_stretch_ctrl_chk #(
    parameter int STRETCH_LIMIT = 300
) (
    input logic clk,
    input logic rst_n,
    input logic start_evt,
    input logic stop_evt,
    input logic byte_valid,
    input logic conv_done,
    input logic hs_mode,
    input logic scl_hold,
    input logic mc_nack
);
    int unsigned hold_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hold_run <= 0;
        else if (scl_hold) hold_run <= hold_run + 1;
        else hold_run <= 0;
    end

    always_comb begin
        if (rst_n) begin
            assert_hold_limit_R10: assert (hold_run <= STRETCH_LIMIT);
        end
    end

    assert_nack_after_byte_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mc_nack |-> $past(byte_valid));
    assert_nack_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mc_nack |=> !mc_nack);
    assert_hs_rise_on_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_mode) |-> $past(start_evt));
    assert_stop_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        stop_evt |=> (!hs_mode && !scl_hold));
    assert_hold_needs_byte_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_hold) |-> $past(byte_valid));
    assert_hold_only_hs_R8: assert property (@(posedge clk) disable iff (!rst_n)
        scl_hold |-> hs_mode);
    assert_release_on_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_hold && conv_done) |=> !scl_hold);
endmodule

bind hs_stretch_ctrl hs_stretch_ctrl_chk #(.STRETCH_LIMIT(STRETCH_LIMIT)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_evt  (start_evt),
    .stop_evt   (stop_evt),
    .byte_valid (byte_valid),
    .conv_done  (conv_done),
    .hs_mode    (hs_mode),
    .scl_hold   (scl_hold),
    .mc_nack    (mc_nack)
);

// File: tb/hs_stretch_ctrl_bench.sv
module hs_stretch_ctrl_bench;
    localparam int LIMIT = 300;
    localparam logic [1:0] SEL = 2'b01;
    localparam logic [7:0] RD_ADDR = {5'b10010, SEL, 1'b1};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_evt = 1'b0, stop_evt = 1'b0, byte_valid = 1'b0, conv_done = 1'b0;
    logic [7:0] byte_data = 8'h00;
    logic hs_mode, scl_hold, mc_nack;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    hs_stretch_ctrl #(.STRETCH_LIMIT(LIMIT)) u_hs_stretch_ctrl (
        .clk(clk), .rst_n(rst_n), .addr_sel(SEL),
        .start_evt(start_evt), .stop_evt(stop_evt),
        .byte_valid(byte_valid), .byte_data(byte_data),
        .conv_done(conv_done), .hs_mode(hs_mode),
        .scl_hold(scl_hold), .mc_nack(mc_nack)
    );

    // {hs before, byte, expected nack, expected hold}
    localparam int NV = 8;
    localparam logic [10:0] VEC [NV] = '{
        {1'b0, 8'h08, 1'b1, 1'b0},
        {1'b0, 8'h0F, 1'b1, 1'b0},
        {1'b0, 8'h10, 1'b0, 1'b0},
        {1'b0, 8'h93, 1'b0, 1'b0},
        {1'b1, 8'h93, 1'b0, 1'b1},
        {1'b1, 8'h92, 1'b0, 1'b0},
        {1'b1, 8'h97, 1'b0, 1'b0},
        {1'b1, 8'h08, 1'b0, 1'b0}
    };

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic pulse_start();
        @(negedge clk); start_evt = 1'b1;
        @(negedge clk); start_evt = 1'b0;
    endtask

    task automatic pulse_stop();
        @(negedge clk); stop_evt = 1'b1;
        @(negedge clk); stop_evt = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b, input logic done);
        @(negedge clk); byte_valid = 1'b1; byte_data = b; conv_done = done;
        @(negedge clk); byte_valid = 1'b0; conv_done = 1'b0;
    endtask

    task automatic enter_hs();
        pulse_stop();
        pulse_start();
        send_byte(8'h08, 1'b0);
        pulse_start();
    endtask

    initial begin
        #2_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 hs_mode", hs_mode, 1'b0);
        check("R1 scl_hold", scl_hold, 1'b0);
        check("R1 mc_nack", mc_nack, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][10]) enter_hs();
            else begin pulse_stop(); pulse_start(); end
            send_byte(VEC[i][9:2], 1'b0);
            check("R2/R4 nack vector", mc_nack, VEC[i][1]);
            check("R7/R8 hold vector", scl_hold, VEC[i][0]);
            if (VEC[i][0]) begin
                @(negedge clk); conv_done = 1'b1;
                @(negedge clk); conv_done = 1'b0;
                check("R9 release in vector", scl_hold, 1'b0);
            end
            pulse_stop();
        end

        // R2 one-cycle nack, R3 entry, R5 keep, R6 leave
        pulse_start();
        send_byte(8'h0A, 1'b0);
        check("R2 hs still low", hs_mode, 1'b0);
        @(negedge clk);
        check("R2 nack one cycle", mc_nack, 1'b0);
        pulse_start();
        check("R3 hs entered", hs_mode, 1'b1);
        pulse_start();
        check("R5 hs kept over Sr", hs_mode, 1'b1);
        pulse_stop();
        check("R6 hs left on stop", hs_mode, 1'b0);

        // R4 preamble as second byte
        pulse_start();
        send_byte(8'h92, 1'b0);
        send_byte(8'h08, 1'b0);
        check("R4 no nack second byte", mc_nack, 1'b0);
        pulse_start();
        check("R4 no hs entry", hs_mode, 1'b0);

        // R6 stop cancels pending preamble
        pulse_stop();
        pulse_start();
        send_byte(8'h08, 1'b0);
        pulse_stop();
        pulse_start();
        check("R6 pending cleared", hs_mode, 1'b0);

        // R7 second byte read address: no hold
        enter_hs();
        send_byte(8'h92, 1'b0);
        send_byte(RD_ADDR, 1'b0);
        check("R7 later byte no hold", scl_hold, 1'b0);

        // R9 exact release timing
        pulse_start();
        send_byte(RD_ADDR, 1'b0);
        repeat (5) @(negedge clk);
        check("R9 held before done", scl_hold, 1'b1);
        conv_done = 1'b1;
        @(negedge clk); conv_done = 1'b0;
        check("R9 released after done", scl_hold, 1'b0);

        // R10 timeout length
        pulse_start();
        send_byte(RD_ADDR, 1'b0);
        begin
            int run = 0;
            while (scl_hold && run < LIMIT + 10) begin
                run++;
                @(negedge clk);
            end
            checks++;
            if (run != LIMIT) begin
                errors++;
                $display("FAIL R10: actual=%0d expected=%0d", run, LIMIT);
            end
        end
        check("R10 hs kept after timeout", hs_mode, 1'b1);

        // R6 stop during hold
        pulse_start();
        send_byte(RD_ADDR, 1'b0);
        check("R6 hold set", scl_hold, 1'b1);
        pulse_stop();
        check("R6 stop releases hold", scl_hold, 1'b0);
        check("R6 stop leaves hs", hs_mode, 1'b0);

        // R11 done coincides with acceptance
        enter_hs();
        send_byte(RD_ADDR, 1'b1);
        check("R11 no hold", scl_hold, 1'b0);
        repeat (3) @(negedge clk);
        check("R11 still no hold", scl_hold, 1'b0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule